// File: doc/BRIEF.md
# PHY Management Serial Controller

This block lets a host read and write the management registers of an Ethernet PHY over the two-wire management link. That link has a clock line (MDC) and a bidirectional data line (MDIO). The host works through two registers. The command register holds the PHY address, the register address and two start bits, one for a read and one for a write. The write-value register holds the 16-bit word for a write, and the host loads it before it sets the write start bit. The host sees results in the command register. A start bit stays set for the whole frame and clears itself when the frame ends. After a read, the low 16 bits of the command register hold the word the PHY returned.

The block makes MDC by dividing the system clock by a parameter. MDC stays low while no frame is running. Every frame has 64 bit slots, sent in this order: 32 preamble ones, start code `01`, opcode, PHY address, register address, turnaround, and 16 data bits with the MSB first. The block changes MDIO on the falling edge of MDC and samples it on the rising edge. A separate output enable controls the pad driver. The host interface is a plain register-write strobe with a live read-back bus, so it has no back-pressure. The host simply polls the start bits.

Top module: `phy_mgmt_ctrl`

## Requirements
- R1: After reset the command read-back is all zero, MDC is low and the MDIO output enable is low. Whenever no frame is running, MDC and the output enable stay low.
- R2: Writing the command register (`reg_sel`=0) with bit 26 set and bit 27 clear starts a read frame. The frame sends 32 ones, `01`, opcode `10`, the 5-bit PHY address from bits 25:21 and the 5-bit register address from bits 20:16, each MSB first.
- R3: When the read frame ends, bit 26 reads 0 and bits 15:0 hold the 16 bits the PHY drove in data slots 48..63, first bit as the MSB. Bits 25:16 read back the addresses.
- R4: Writing the command register with bit 27 set starts a write frame. The frame sends 32 ones, `01`, opcode `01`, the addresses, turnaround `10`, then bits 15:0 of the write-value register (`reg_sel`=1), MSB first. Bit 27 reads 0 when the frame ends, and bits 15:0 keep their earlier value.
- R5: The set start bit reads 1 for exactly 64×`MDC_DIV` clock cycles, counted from the edge that captures the command. The frame contains exactly 64 MDC rising edges.
- R6: MDC toggles every `MDC_DIV`/2 clock cycles during a frame, and its first rise comes `MDC_DIV`/2 cycles after the start. MDIO changes only on MDC falling edges.
- R7: In a read frame, the output enable is low from the turnaround slots (46, 47) through the last data slot. It is high in every other slot, and high in every slot of a write frame.
- R8: A command-register write that arrives while a frame runs has no effect. Addresses, start bits and the running frame stay unchanged.
- R9: When bits 26 and 27 are both set, the block runs a read, and only bit 26 reads back as set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the command register, 1 selects the write-value register |
| reg_wdata | input | 28 | Write data: command fields, or the write value in bits 15:0 |
| cmd_rdata | output | 28 | Command register read-back: {wr_go, rd_go, phy, reg, data} |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The timing is fixed by the command-capture edge. The start bit rises on that edge and falls exactly 64×`MDC_DIV` cycles later. The read word appears in the read-back on the same edge that clears the bit. MDC rises `MDC_DIV`/2 cycles after the start and toggles at that spacing from then on. The bench samples every output on the falling clock edge. It counts the cycles the start bit is high and the spacing between MDC toggles, and it compares both against these figures. A PHY model records MDIO and the output enable on each MDC rising edge. It also drives read data on MDC falling edges. At the cycle the start bit falls, a scoreboard pops the expected frame, enable pattern and read-back, and compares them.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int PHY_AW     = 5;
  localparam int REG_AW     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int TA_FIRST   = PRE_BITS + 2 + 2 + PHY_AW + REG_AW;
  localparam int DATA_FIRST = TA_FIRST + 2;
  localparam int FRAME_BITS = DATA_FIRST + DATA_W;

  // Command register layout
  localparam int F_REG_LSB = DATA_W;
  localparam int F_PHY_LSB = F_REG_LSB + REG_AW;
  localparam int F_RD_BIT  = F_PHY_LSB + PHY_AW;
  localparam int F_WR_BIT  = F_RD_BIT + 1;
  localparam int CMD_W     = F_WR_BIT + 1;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mgmt_op_e;

  typedef struct packed {
    logic [PHY_AW-1:0] phy;
    logic [REG_AW-1:0] regad;
    logic              is_rd;
  } mgmt_req_t;
endpackage

// File: rtl/mgmt_clk_div.sv
module mgmt_clk_div #(
  parameter int DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);

  logic [CW-1:0] cnt;

  assign rise_tick = run && (cnt == CW'(HALF - 1));
  assign fall_tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= fall_tick ? '0 : cnt + 1'b1;
      if (rise_tick) mdc <= 1'b1;
      if (fall_tick) mdc <= 1'b0;
    end
  end
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mgmt_req_t         req,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              active,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] shift;
  logic [IW-1:0]         idx;
  logic                  is_rd_q;
  logic [1:0]            op_code;
  logic [1:0]            ta_code;
  logic [DATA_W-1:0]     data_fill;

  assign op_code   = req.is_rd ? OP_READ : OP_WRITE;
  assign ta_code   = req.is_rd ? 2'b11 : 2'b10;
  assign data_fill = req.is_rd ? '1 : wdata;

  assign done    = active && fall_tick && (idx == IW'(FRAME_BITS - 1));
  assign mdio_o  = shift[FRAME_BITS-1];
  assign mdio_oe = active && !(is_rd_q && (int'(idx) >= TA_FIRST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift   <= '0;
      idx     <= '0;
      active  <= 1'b0;
      is_rd_q <= 1'b0;
      rd_data <= '0;
    end else if (start && !active) begin
      shift   <= {{PRE_BITS{1'b1}}, 2'b01, op_code, req.phy, req.regad, ta_code, data_fill};
      idx     <= '0;
      active  <= 1'b1;
      is_rd_q <= req.is_rd;
    end else if (active) begin
      if (rise_tick && is_rd_q && (int'(idx) >= DATA_FIRST))
        rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      if (done) begin
        active <= 1'b0;
      end else if (fall_tick) begin
        shift <= {shift[FRAME_BITS-2:0], 1'b1};
        idx   <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int MDC_DIV = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [CMD_W-1:0] reg_wdata,
  output logic [CMD_W-1:0] cmd_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic              rd_go, wr_go, busy;
  logic [PHY_AW-1:0] phy_q;
  logic [REG_AW-1:0] reg_q;
  logic [DATA_W-1:0] wval_q, rdata_q, eng_rd;
  logic              cmd_wr, req_rd, req_wr, start;
  logic              rise_tick, fall_tick, eng_active, eng_done;
  mgmt_req_t         req;

  assign busy   = rd_go || wr_go;
  assign cmd_wr = reg_wr && !reg_sel;
  assign req_rd = reg_wdata[F_RD_BIT];
  assign req_wr = reg_wdata[F_WR_BIT] && !req_rd;
  assign start  = cmd_wr && !busy && (req_rd || req_wr);

  assign req.phy   = reg_wdata[F_PHY_LSB +: PHY_AW];
  assign req.regad = reg_wdata[F_REG_LSB +: REG_AW];
  assign req.is_rd = req_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_go   <= 1'b0;
      wr_go   <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      wval_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (cmd_wr && !busy) begin
        phy_q <= req.phy;
        reg_q <= req.regad;
        rd_go <= req_rd;
        wr_go <= req_wr;
      end else if (eng_done) begin
        rd_go <= 1'b0;
        wr_go <= 1'b0;
        if (rd_go) rdata_q <= eng_rd;
      end
      if (reg_wr && reg_sel) wval_q <= reg_wdata[DATA_W-1:0];
    end
  end

  assign cmd_rdata = {wr_go, rd_go, phy_q, reg_q, rdata_q};

  mgmt_clk_div #(.DIV(MDC_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mgmt_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .req(req), .wdata(wval_q),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .active(eng_active), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(eng_done), .rd_data(eng_rd)
  );

  logic unused_active;
  assign unused_active = eng_active;
endmodule

// File: rtl/phy_mgmt_ctrl_chk.sv
module phy_mgmt_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic [11:0] cmd_hi,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  logic       busy, is_rd, mdc_q;
  logic [6:0] rises;

  assign busy  = cmd_hi[11] || cmd_hi[10];
  assign is_rd = cmd_hi[10];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_q <= 1'b0;
      rises <= '0;
    end else begin
      mdc_q <= mdc;
      if (!busy) rises <= '0;
      else if (mdc && !mdc_q) rises <= rises + 1'b1;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R6
  mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && !reg_sel) |=> $stable(cmd_hi[9:0]));

  // R7
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_rd && ((rises >= 7'd47) || (rises == 7'd46 && !mdc))) |-> !mdio_oe);

  // R5
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (rises == 7'd64));
endmodule

bind phy_mgmt_ctrl phy_mgmt_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .cmd_hi(cmd_rdata[27:16]), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/phy_mgmt_ctrl_bench.sv
module phy_mgmt_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int DIV   = 40;
  localparam int HALF  = DIV / 2;

  typedef struct {
    logic [63:0] frm;
    logic [63:0] oe;
    logic [27:0] cmd;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [27:0] reg_wdata = '0;
  logic [27:0] cmd_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0, fails = 0;
  exp_t q[$];

  logic [15:0] phy_val = '0;
  logic [15:0] last_rd = '0;
  logic [63:0] frame_cap = '0, oe_cap = '0;
  int          rise_n = 0;

  always #(CLK_P/2) clk = ~clk;

  phy_mgmt_ctrl #(.MDC_DIV(DIV)) u_phy_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cmd_rdata(cmd_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // PHY model: record on MDC rise, drive read data after MDC fall
  always @(posedge mdc) begin
    frame_cap = {frame_cap[62:0], mdio_o};
    oe_cap    = {oe_cap[62:0], mdio_oe};
    rise_n    = rise_n + 1;
  end
  always @(negedge mdc) begin
    if (rise_n >= 48 && rise_n <= 63) mdio_i = phy_val[63-rise_n];
    else mdio_i = 1'b1;
  end

  task automatic host_write(input logic sel, input logic [27:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Driver: push expected results, then issue the command
  task automatic run_frame(input logic rd, input logic wr, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] wv,
                           input logic [15:0] pv);
    exp_t e;
    logic is_rd;
    is_rd = rd;
    if (!is_rd) host_write(1'b1, {12'h0, wv});
    phy_val = pv;
    rise_n = 0;
    frame_cap = '0;
    oe_cap = '0;
    e.frm = {32'hFFFF_FFFF, 2'b01, (is_rd ? 2'b10 : 2'b01), phy, rg,
             (is_rd ? 2'b00 : 2'b10), (is_rd ? pv : wv)};
    e.oe  = is_rd ? 64'hFFFF_FFFF_FFFC_0000 : '1;
    if (is_rd) last_rd = pv;
    e.cmd = {2'b00, phy, rg, last_rd};
    q.push_back(e);
    host_write(1'b0, {wr, rd, phy, rg, 16'h0});
  endtask

  task automatic wait_idle();
    while (cmd_rdata[27] || cmd_rdata[26]) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Monitor / scoreboard
  logic busy_p = 1'b0, mdc_p = 1'b0, mo_p = 1'b0, tbad = 1'b0;
  int   bcyc = 0, seg = 0;
  always @(negedge clk) begin
    logic busy;
    busy = cmd_rdata[27] || cmd_rdata[26];
    if (busy && !busy_p) begin
      bcyc = 1; seg = 0; tbad = 1'b0;
    end else if (busy) begin
      bcyc++; seg++;
      if (mdc != mdc_p) begin
        if (seg != HALF) tbad = 1'b1;
        seg = 0;
      end
      if (mdio_o != mo_p && !(mdc_p && !mdc)) tbad = 1'b1;
    end
    if (busy_p && !busy) begin
      if (q.size() == 0) begin
        check(1'b0, "R2 unexpected frame", 64'(cmd_rdata), 64'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check((frame_cap & e.oe) == (e.frm & e.oe), "R2/R4 frame bits",
              frame_cap & e.oe, e.frm & e.oe);
        check(oe_cap == e.oe, "R7 output enable", oe_cap, e.oe);
        check(cmd_rdata == e.cmd, "R3/R4/R9 read-back", 64'(cmd_rdata), 64'(e.cmd));
        check(bcyc == 64*DIV, "R5 busy cycles", 64'(bcyc), 64'(64*DIV));
        check(rise_n == 64, "R5 MDC rises", 64'(rise_n), 64'd64);
        check(!tbad, "R6 MDC spacing and MDIO edges", 64'(tbad), 64'd0);
        check(!mdc && !mdio_oe, "R1 idle after frame", {62'h0, mdc, mdio_oe}, 64'h0);
      end
    end
    busy_p = busy; mdc_p = mdc; mo_p = mdio_o;
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog: actual hung expected frames complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cmd_rdata == '0, "R1 reset read-back", 64'(cmd_rdata), 64'h0);
    check(!mdc, "R1 reset mdc", 64'(mdc), 64'h0);
    check(!mdio_oe, "R1 reset output enable", 64'(mdio_oe), 64'h0);

    // R2 R3 read
    run_frame(1'b1, 1'b0, 5'h01, 5'h02, 16'h0, 16'hA5C3);
    wait_idle();
    // R4 write
    run_frame(1'b0, 1'b1, 5'h1F, 5'h00, 16'h8001, 16'h0);
    wait_idle();
    // R3 boundary data and addresses
    run_frame(1'b1, 1'b0, 5'h00, 5'h1F, 16'h0, 16'hFFFF);
    wait_idle();
    run_frame(1'b1, 1'b0, 5'h15, 5'h0A, 16'h0, 16'h0000);
    wait_idle();

    // R8 command written mid-frame is ignored
    run_frame(1'b1, 1'b0, 5'h0A, 5'h15, 16'h0, 16'h1234);
    repeat (600) @(negedge clk);
    host_write(1'b0, {1'b1, 1'b0, 5'h03, 5'h03, 16'h0});
    check(cmd_rdata[27:16] == {1'b0, 1'b1, 5'h0A, 5'h15}, "R8 fields after ignored write",
          64'(cmd_rdata[27:16]), 64'({1'b0, 1'b1, 5'h0A, 5'h15}));
    wait_idle();

    // R9 both start bits: read wins
    run_frame(1'b1, 1'b1, 5'h12, 5'h0C, 16'h0, 16'h0F0F);
    wait_idle();
    // R4 all-zero write
    run_frame(1'b0, 1'b1, 5'h00, 5'h00, 16'h0000, 16'h0);
    wait_idle();

    check(q.size() == 0, "R5 all frames completed", 64'(q.size()), 64'h0);
    finish_run();
  end
endmodule